// File: doc/BRIEF.md
# Hidden Timing-Register Gate for a Disk Channel

This block sits on the device side of a parallel disk interface channel. It watches the host's I/O accesses on a small port addressed by a 3-bit offset. Each access is a read or a write, either 8 or 16 bits wide. While the gate is closed, every access reaches a plain array of task-file registers.

A short in-band sequence opens a configuration window. The host makes two back-to-back 16-bit reads of offset 1, then writes the byte 3 to offset 2. While the window is open, byte writes go to a small set of timing and control registers instead of the task file. Writing the byte 0x83 to offset 2 closes the window again.

The block drives the effective read-cycle and write-cycle timing values to the channel's timing logic. These values come from the strap defaults until the control register holds the override key. Software can also read back the clock-speed strap pin through the strap register.

Top module: `trapdoor_cfg_port`

## Requirements
- R1: After reset the gate is closed (`cfg_open`=0), `timing_override`=0, and both effective timings equal the strap default: DEF_SLOW (0x6B) when `strap_pin`=0 and DEF_FAST (0x58) when `strap_pin`=1.
- R2: Every read access produces `rd_valid` on the following cycle, and no other access does. While closed, a 16-bit write stores all 16 bits of the task-file entry at the offset. A byte write changes only bits 7:0. A 16-bit read returns the whole entry, and a byte read returns bits 7:0 with zeros above.
- R3: The gate opens after exactly this sequence of valid accesses: a 16-bit read of offset 1, a second 16-bit read of offset 1, then a byte write of 0x03 to offset 2. Idle cycles between the accesses do not disturb the sequence.
- R4: Any valid access that is not the expected next step restarts the sequence from its beginning. This includes a third 16-bit read of offset 1 after the two arming reads, and it leaves the gate closed.
- R5: While the gate is open, byte writes reach the configuration registers, selected by offset: 0 read timing, 1 write timing, 3 control, 5 strap, 6 miscellaneous. While the gate is closed, writes never reach them. While the gate is open, writes never reach the task file.
- R6: While the gate is open, a write to offset 2, 4 or 7 (other than the close key), or any 16-bit write, is ignored. Reads of offsets 2, 4 and 7 return zero.
- R7: A read of offset 5 returns the stored strap byte with bit 0 replaced. Bit 0 is 0 until a value with bit 0 set has been written to the strap register. After that, bit 0 follows the `strap_pin` input.
- R8: While the control register holds 0x85, `timing_override`=1 and the effective timings are the programmed read/write timing registers. For any other control value, the effective timings are the strap defaults.
- R9: A byte write of 0x83 to offset 2 while the gate is open closes it. Later accesses reach the task file again, and the configuration registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| acc_off | input | 3 | Port offset |
| acc_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| strap_pin | input | 1 | Clock-speed strap, 1 = fast clock |
| rd_valid | output | 1 | Read data valid, one cycle after a read access |
| rd_data | output | 16 | Read data |
| cfg_open | output | 1 | Configuration window is open |
| timing_override | output | 1 | Programmed timings are in force |
| eff_read_tim | output | 8 | Effective read-cycle timing |
| eff_write_tim | output | 8 | Effective write-cycle timing |
| misc_cfg | output | 8 | Miscellaneous configuration register |

## Verification
A sequencer stuck in a half-armed state shows up on the next byte write of 3 to offset 2: `cfg_open` rises when it should not, or stays low when it should rise. From that cycle on, writes land in the wrong register set, and a later read of either set returns a value the scoreboard does not expect. A wrong write decode, or a missed override compare, shows up one cycle after the write, on `eff_read_tim` and `eff_write_tim` or on the next readback through `rd_data`.

// File: rtl/trapdoor_pkg.sv
// Shared state type and fixed offsets/keys for the trapdoor configuration port.
// Assumes a 3-bit port offset; the offsets below are behaviour, not layout.
package trapdoor_pkg;
    typedef enum logic [1:0] {
        TD_IDLE  = 2'd0,
        TD_ONE   = 2'd1,
        TD_ARMED = 2'd2,
        TD_OPEN  = 2'd3
    } td_state_e;

    localparam logic [2:0] OFF_RDTIM = 3'd0;
    localparam logic [2:0] OFF_WRTIM = 3'd1;
    localparam logic [2:0] OFF_GATE  = 3'd2;
    localparam logic [2:0] OFF_CTL   = 3'd3;
    localparam logic [2:0] OFF_STRAP = 3'd5;
    localparam logic [2:0] OFF_MISC  = 3'd6;
    localparam logic [2:0] OFF_ARM   = 3'd1;

    localparam logic [7:0] KEY_OPEN     = 8'h03;
    localparam logic [7:0] KEY_CLOSE    = 8'h83;
    localparam logic [7:0] KEY_OVERRIDE = 8'h85;
endpackage

// File: rtl/trapdoor_seq.sv
// Unlock sequencer: tracks the arming reads and the open/close key writes.
// Assumes one access per valid cycle; idle cycles hold the state.
module trapdoor_seq
    import trapdoor_pkg::*;
#(
    parameter int OFF_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_wide,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              open
);
    td_state_e state_q, state_d;
    logic is_arm_rd, is_key_open, is_key_close;

    // Classify the current access against the sequence steps.
    always_comb begin
        is_arm_rd    = acc_valid && !acc_write && acc_wide && (acc_off == OFF_ARM);
        is_key_open  = acc_valid && acc_write && !acc_wide && (acc_off == OFF_GATE)
                       && (acc_wdata[7:0] == KEY_OPEN);
        is_key_close = acc_valid && acc_write && !acc_wide && (acc_off == OFF_GATE)
                       && (acc_wdata[7:0] == KEY_CLOSE);
    end

    // Next-state: any unexpected valid access restarts the arming count.
    always_comb begin
        state_d = state_q;
        if (acc_valid) begin
            unique case (state_q)
                TD_IDLE:  state_d = is_arm_rd   ? TD_ONE   : TD_IDLE;
                TD_ONE:   state_d = is_arm_rd   ? TD_ARMED : TD_IDLE;
                TD_ARMED: state_d = is_key_open ? TD_OPEN  : TD_IDLE;
                TD_OPEN:  state_d = is_key_close ? TD_IDLE : TD_OPEN;
                default:  state_d = TD_IDLE;
            endcase
        end
    end

    // State register with synchronous reset to locked.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TD_IDLE;
        else        state_q <= state_d;
    end

    assign open = (state_q == TD_OPEN);
endmodule

// File: rtl/trapdoor_taskfile.sv
// Plain task-file register array reached while the gate is closed.
// Assumes byte writes update only the low byte of an entry.
module trapdoor_taskfile #(
    parameter int OFF_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              acc_wide,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << OFF_W;
    localparam int LO_W  = 8;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Per-entry storage, full or low-byte update.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (wr_en && (acc_off == OFF_W'(i))) begin
                if (acc_wide) mem_q[i] <= acc_wdata;
                else          mem_q[i][LO_W-1:0] <= acc_wdata[LO_W-1:0];
            end
        end
    end

    // Read view: byte reads return the low byte zero-extended.
    always_comb begin
        rdata = mem_q[acc_off];
        if (!acc_wide) rdata[DATA_W-1:LO_W] = '0;
    end
endmodule

// File: rtl/trapdoor_cfgregs.sv
// Hidden timing/control registers and effective-timing selection.
// Assumes writes arrive only as byte writes while the gate is open.
module trapdoor_cfgregs
    import trapdoor_pkg::*;
#(
    parameter int OFF_W = 3,
    parameter int DATA_W = 16,
    parameter int REG_W = 8,
    parameter logic [REG_W-1:0] DEF_SLOW = 8'h6B,
    parameter logic [REG_W-1:0] DEF_FAST = 8'h58
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              strap_pin,
    output logic [DATA_W-1:0] rdata,
    output logic              override,
    output logic [REG_W-1:0]  eff_rd,
    output logic [REG_W-1:0]  eff_wr,
    output logic [REG_W-1:0]  misc
);
    logic [REG_W-1:0] rdtim_q, wrtim_q, ctl_q, strap_q, misc_q;
    logic [REG_W-1:0] wbyte, def_tim;

    assign wbyte = acc_wdata[REG_W-1:0];

    // Register writes decoded by offset; unmapped offsets fall through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdtim_q <= '0;
            wrtim_q <= '0;
            ctl_q   <= '0;
            strap_q <= '0;
            misc_q  <= '0;
        end else if (wr_en) begin
            case (acc_off)
                OFF_RDTIM: rdtim_q <= wbyte;
                OFF_WRTIM: wrtim_q <= wbyte;
                OFF_CTL:   ctl_q   <= wbyte;
                OFF_STRAP: strap_q <= wbyte;
                OFF_MISC:  misc_q  <= wbyte;
                default:   ;
            endcase
        end
    end

    // Read mux; strap bit 0 reports the pin once sampling is enabled.
    always_comb begin
        rdata = '0;
        case (acc_off)
            OFF_RDTIM: rdata[REG_W-1:0] = rdtim_q;
            OFF_WRTIM: rdata[REG_W-1:0] = wrtim_q;
            OFF_CTL:   rdata[REG_W-1:0] = ctl_q;
            OFF_STRAP: rdata[REG_W-1:0] = {strap_q[REG_W-1:1], strap_q[0] & strap_pin};
            OFF_MISC:  rdata[REG_W-1:0] = misc_q;
            default:   rdata = '0;
        endcase
    end

    // Effective timing: programmed values only under the override key.
    always_comb begin
        def_tim  = strap_pin ? DEF_FAST : DEF_SLOW;
        override = (ctl_q == KEY_OVERRIDE);
        eff_rd   = override ? rdtim_q : def_tim;
        eff_wr   = override ? wrtim_q : def_tim;
    end

    assign misc = misc_q;
endmodule

// File: rtl/trapdoor_cfg_port.sv
// Top: routes host accesses to the task file or the hidden registers and
// returns read data one cycle after each read. Synchronous active-low reset.
module trapdoor_cfg_port #(
    parameter int OFF_W = 3,
    parameter int DATA_W = 16,
    parameter int REG_W = 8,
    parameter logic [REG_W-1:0] DEF_SLOW = 8'h6B,
    parameter logic [REG_W-1:0] DEF_FAST = 8'h58
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_wide,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              strap_pin,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              cfg_open,
    output logic              timing_override,
    output logic [REG_W-1:0]  eff_read_tim,
    output logic [REG_W-1:0]  eff_write_tim,
    output logic [REG_W-1:0]  misc_cfg
);
    logic [DATA_W-1:0] tf_rdata, cfg_rdata;
    logic tf_wr, cfg_wr;

    trapdoor_seq #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_wide(acc_wide), .acc_off(acc_off), .acc_wdata(acc_wdata), .open(cfg_open)
    );

    // Write steering: closed -> task file; open -> byte writes to config.
    always_comb begin
        tf_wr  = acc_valid && acc_write && !cfg_open;
        cfg_wr = acc_valid && acc_write && cfg_open && !acc_wide;
    end

    trapdoor_taskfile #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_tf (
        .clk(clk), .rst_n(rst_n), .wr_en(tf_wr), .acc_wide(acc_wide),
        .acc_off(acc_off), .acc_wdata(acc_wdata), .rdata(tf_rdata)
    );

    trapdoor_cfgregs #(.OFF_W(OFF_W), .DATA_W(DATA_W), .REG_W(REG_W),
                       .DEF_SLOW(DEF_SLOW), .DEF_FAST(DEF_FAST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .acc_off(acc_off),
        .acc_wdata(acc_wdata), .strap_pin(strap_pin), .rdata(cfg_rdata),
        .override(timing_override), .eff_rd(eff_read_tim), .eff_wr(eff_write_tim),
        .misc(misc_cfg)
    );

    // Read response register: one cycle after the read access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_valid && !acc_write;
            if (acc_valid && !acc_write) rd_data <= cfg_open ? cfg_rdata : tf_rdata;
        end
    end
endmodule

// File: rtl/trapdoor_cfg_port_chk.sv
// Temporal checks on the trapdoor port, bound to the top module.
module trapdoor_cfg_port_chk #(
    parameter int OFF_W = 3,
    parameter int DATA_W = 16,
    parameter int REG_W = 8,
    parameter logic [REG_W-1:0] DEF_SLOW = 8'h6B,
    parameter logic [REG_W-1:0] DEF_FAST = 8'h58
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic              acc_wide,
    input logic [OFF_W-1:0]  acc_off,
    input logic [DATA_W-1:0] acc_wdata,
    input logic              strap_pin,
    input logic              rd_valid,
    input logic              cfg_open,
    input logic              timing_override,
    input logic [REG_W-1:0]  eff_read_tim
);
    logic key_wr, close_wr;
    assign key_wr   = acc_valid && acc_write && !acc_wide && (acc_off == 3'd2)
                      && (acc_wdata[7:0] == 8'h03);
    assign close_wr = acc_valid && acc_write && !acc_wide && (acc_off == 3'd2)
                      && (acc_wdata[7:0] == 8'h83);

    p_reset_locked_r1: assert property (@(posedge clk) !rst_n |=> !cfg_open);

    p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> rd_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !rd_valid);

    p_open_by_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(key_wr));

    p_locked_no_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && acc_valid && acc_write) |=> $stable(timing_override));

    p_default_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !timing_override |-> (eff_read_tim == (strap_pin ? DEF_FAST : DEF_SLOW)));

    p_relock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && close_wr) |=> !cfg_open);
endmodule

bind trapdoor_cfg_port trapdoor_cfg_port_chk #(
    .OFF_W(OFF_W), .DATA_W(DATA_W), .REG_W(REG_W),
    .DEF_SLOW(DEF_SLOW), .DEF_FAST(DEF_FAST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_wide(acc_wide), .acc_off(acc_off), .acc_wdata(acc_wdata),
    .strap_pin(strap_pin), .rd_valid(rd_valid), .cfg_open(cfg_open),
    .timing_override(timing_override), .eff_read_tim(eff_read_tim)
);

// File: tb/trapdoor_cfg_port_test.sv
// Scoreboard bench: read tasks queue expected data, a monitor compares it.
module trapdoor_cfg_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0, acc_wide = 1'b0;
    logic [2:0] acc_off = '0;
    logic [15:0] acc_wdata = '0;
    logic strap_pin = 1'b0;
    logic rd_valid, cfg_open, timing_override;
    logic [15:0] rd_data;
    logic [7:0] eff_read_tim, eff_write_tim, misc_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    trapdoor_cfg_port uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_wide(acc_wide), .acc_off(acc_off), .acc_wdata(acc_wdata),
        .strap_pin(strap_pin), .rd_valid(rd_valid), .rd_data(rd_data),
        .cfg_open(cfg_open), .timing_override(timing_override),
        .eff_read_tim(eff_read_tim), .eff_write_tim(eff_write_tim), .misc_cfg(misc_cfg)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(bit wr, bit wide, logic [2:0] off, logic [15:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_wide = wide; acc_off = off; acc_wdata = d;
        @(posedge clk);
        #1 acc_valid = 1'b0;
    endtask

    task automatic rd(bit wide, logic [2:0] off, logic [15:0] exp, string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        access(1'b0, wide, off, 16'h0);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    // Monitor: compare each returned read against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2: actual=%h expected=no read", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();
        check("R1 open", {15'b0, cfg_open}, 16'h0);
        check("R1 ovr", {15'b0, timing_override}, 16'h0);
        check("R1 rdtim", {8'h0, eff_read_tim}, 16'h006B);
        check("R1 wrtim", {8'h0, eff_write_tim}, 16'h006B);

        // R2 task file wide/byte behaviour
        access(1, 1, 3'd3, 16'hBEEF);
        rd(1, 3'd3, 16'hBEEF, "R2 wide");
        access(1, 0, 3'd3, 16'h0012);
        rd(1, 3'd3, 16'hBE12, "R2 byte merge");
        rd(0, 3'd3, 16'h0012, "R2 byte read");

        // R4 broken sequences
        rd(1, 3'd1, 16'h0, "R4 arm");
        rd(0, 3'd1, 16'h0, "R4 narrow");
        rd(1, 3'd1, 16'h0, "R4 arm");
        access(1, 0, 3'd2, 16'h0003);
        settle();
        check("R4 broken", {15'b0, cfg_open}, 16'h0);
        rd(1, 3'd1, 16'h0, "R4 a1");
        rd(1, 3'd1, 16'h0, "R4 a2");
        rd(1, 3'd1, 16'h0, "R4 a3");
        access(1, 0, 3'd2, 16'h0003);
        settle();
        check("R4 third read", {15'b0, cfg_open}, 16'h0);

        // R3 proper unlock with an idle gap
        rd(1, 3'd1, 16'h0, "R3 a1");
        settle();
        rd(1, 3'd1, 16'h0, "R3 a2");
        access(1, 0, 3'd2, 16'h0003);
        settle();
        check("R3 open", {15'b0, cfg_open}, 16'h1);

        // R5 config writes and readback
        access(1, 0, 3'd0, 16'h0044);
        access(1, 0, 3'd1, 16'h0032);
        access(1, 0, 3'd6, 16'h0010);
        rd(0, 3'd0, 16'h0044, "R5 rdtim");
        rd(1, 3'd1, 16'h0032, "R5 wrtim");
        rd(1, 3'd6, 16'h0010, "R5 misc");
        settle();
        check("R5 misc out", {8'h0, misc_cfg}, 16'h0010);
        check("R8 no key", {8'h0, eff_read_tim}, 16'h006B);

        // R6 ignored offsets and wide writes
        access(1, 0, 3'd4, 16'h0077);
        access(1, 1, 3'd0, 16'hAAAA);
        access(1, 0, 3'd2, 16'h0055);
        rd(1, 3'd4, 16'h0, "R6 off4");
        rd(1, 3'd0, 16'h0044, "R6 wide ignored");
        rd(1, 3'd2, 16'h0, "R6 off2");
        rd(1, 3'd7, 16'h0, "R6 off7");
        settle();
        check("R6 still open", {15'b0, cfg_open}, 16'h1);

        // R7 strap readback
        strap_pin = 1'b1;
        settle();
        check("R1 fast default", {8'h0, eff_read_tim}, 16'h0058);
        rd(1, 3'd5, 16'h0, "R7 before enable");
        access(1, 0, 3'd5, 16'h00FF);
        rd(1, 3'd5, 16'h00FF, "R7 pin high");
        strap_pin = 1'b0;
        rd(1, 3'd5, 16'h00FE, "R7 pin low");

        // R8 override key
        access(1, 0, 3'd3, 16'h0084);
        settle();
        check("R8 wrong key", {7'b0, timing_override, eff_read_tim}, 16'h006B);
        access(1, 0, 3'd3, 16'h0085);
        settle();
        check("R8 ovr", {15'b0, timing_override}, 16'h1);
        check("R8 rd", {8'h0, eff_read_tim}, 16'h0044);
        check("R8 wr", {8'h0, eff_write_tim}, 16'h0032);
        rd(0, 3'd3, 16'h0085, "R8 ctl read");

        // R9 relock; task file untouched by config traffic
        access(1, 0, 3'd2, 16'h0083);
        settle();
        check("R9 closed", {15'b0, cfg_open}, 16'h0);
        rd(1, 3'd4, 16'h0, "R6 tf4 untouched");
        rd(1, 3'd0, 16'h0, "R5 tf0 untouched");
        access(1, 0, 3'd0, 16'h0055);
        rd(1, 3'd0, 16'h0055, "R9 tf reached");
        settle();
        check("R5 locked write", {8'h0, eff_read_tim}, 16'h0044);
        check("R9 regs kept", {8'h0, eff_write_tim}, 16'h0032);

        repeat (3) @(negedge clk);
        check("R2 all reads returned", 16'(exp_q.size()), 16'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule